// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a one-bit serial stream, one bit per rising clock edge, and flags each place where the four most recent bits read 1, 0, 1, 1 in arrival order. The flag is a Mealy output. It is high during the cycle in which the closing 1 is on the input, so a consumer sees the match in the same cycle as the bit that completes it. The consumer must sample the flag on the clock edge, because it follows the input combinationally between edges.

A match can reuse the tail of an earlier match. After a full match, the trailing 1 counts as the start of the next attempt, so the stream 1011011 gives two matches. Two bits of state record how much of the pattern has been seen. The input is assumed to be synchronous to the clock already. An active-high asynchronous reset returns the detector to its empty state.

The states are:
- IDLE (00): nothing matched.
- GOT_1 (01): "1" seen.
- GOT_10 (10): "10" seen.
- GOT_101 (11): "101" seen.

The transitions are:
- IDLE: a 0 stays in IDLE, a 1 moves to GOT_1.
- GOT_1: a 1 stays in GOT_1, a 0 moves to GOT_10.
- GOT_10: a 1 moves to GOT_101, a 0 falls back to IDLE.
- GOT_101: a 0 falls back to GOT_10, a 1 moves to GOT_1 and raises the flag.

Top module: `serial_match_fsm`

## Requirements
- R1: While rst_i is high the state is IDLE (00) at once, without waiting for a clock edge. While the state is IDLE, hit_o is 0.
- R2: The state uses a two-bit encoding: IDLE=00, GOT_1=01, GOT_10=10, GOT_101=11. On every edge, the low state bit takes the value of bit_i.
- R3: hit_o is 1 exactly when the state is GOT_101 and bit_i is 1. It is 0 otherwise.
- R4: From IDLE, a 0 stays in IDLE and a 1 goes to GOT_1. From GOT_1, a 1 stays in GOT_1 and a 0 goes to GOT_10.
- R5: From GOT_10, a 1 goes to GOT_101 and a 0 goes to IDLE. From GOT_101, a 0 goes to GOT_10 and a 1 goes to GOT_1.
- R6: Matches overlap. The stream 1011011, applied from IDLE, raises hit_o on the 4th bit and on the 7th bit only.
- R7: The stream 10011, applied from IDLE, never raises hit_o.
- R8: The state changes only on a rising clock edge. Between edges, hit_o follows bit_i combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_i | input | 1 | Asynchronous reset, active high |
| bit_i | input | 1 | Serial data bit, synchronous to clk_i |
| hit_o | output | 1 | Mealy match flag for the pattern 1011 |

## Verification
A reference model shifts the last four input bits through a register and compares each sampled flag with that window equal to 1011. Six kinds of stimulus are used:
- The overlapping stream 1011011 separates true overlap handling from a detector that restarts after each match.
- The near-miss stream 10011 catches a wrong fallback from GOT_10.
- Runs of zeros and runs of ones test the self-loops in IDLE and GOT_1.
- The streams 1010 and 10111 test each exit from GOT_10 and GOT_101.
- A long pseudo-random stream covers every transition in mixed order.
- Two directed tests cover the edges: toggling the input inside one cycle shows that the flag is combinational, and a reset pulse between edges shows that the reset does not wait for a clock.

// File: rtl/smatch_pkg.sv
package smatch_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 2'b00,
        ST_GOT1    = 2'b01,
        ST_GOT10   = 2'b10,
        ST_GOT101  = 2'b11
    } smatch_state_t;

endpackage

// File: rtl/smatch_next.sv
module smatch_next
    import smatch_pkg::*;
(
    input  smatch_state_t cur_i,
    input  logic          bit_i,
    output smatch_state_t nxt_o
);

    always_comb begin
        nxt_o = ST_IDLE;
        unique case (cur_i)
            ST_IDLE:   nxt_o = bit_i ? ST_GOT1   : ST_IDLE;
            ST_GOT1:   nxt_o = bit_i ? ST_GOT1   : ST_GOT10;
            ST_GOT10:  nxt_o = bit_i ? ST_GOT101 : ST_IDLE;
            ST_GOT101: nxt_o = bit_i ? ST_GOT1   : ST_GOT10;
            default:   nxt_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/smatch_out.sv
module smatch_out
    import smatch_pkg::*;
(
    input  smatch_state_t cur_i,
    input  logic          bit_i,
    output logic          hit_o
);

    always_comb begin
        hit_o = 1'b0;
        unique case (cur_i)
            ST_IDLE:   hit_o = 1'b0;
            ST_GOT1:   hit_o = 1'b0;
            ST_GOT10:  hit_o = 1'b0;
            ST_GOT101: hit_o = bit_i;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_match_fsm.sv
module serial_match_fsm
    import smatch_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic hit_o
);

    smatch_state_t state_q;
    smatch_state_t state_d;

    smatch_next u_next (
        .cur_i (state_q),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    smatch_out u_out (
        .cur_i (state_q),
        .bit_i (bit_i),
        .hit_o (hit_o)
    );

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

endmodule

// File: rtl/smatch_chk.sv
module smatch_chk (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       hit,
    input logic [1:0] st
);

    assert_reset_idle_R1: assert property (@(posedge clk) rst |-> (st == 2'b00 && !hit));

    assert_low_bit_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st[0] == $past(din)));

    assert_hit_only_in_101_R3: assert property (@(posedge clk) disable iff (rst)
        hit == (st == 2'b11 && din));

    assert_idle_zero_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b00 && !din) |=> (st == 2'b00));

    assert_got1_zero_to_10_R4: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b01 && !din) |=> (st == 2'b10));

    assert_got10_zero_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b10 && !din) |=> (st == 2'b00));

    assert_got101_one_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b11 && din) |=> (st == 2'b01));

endmodule

bind serial_match_fsm smatch_chk chk_i (
    .clk (clk_i),
    .rst (rst_i),
    .din (bit_i),
    .hit (hit_o),
    .st  (state_q)
);

// File: tb/serial_match_fsm_tb_top.sv
`timescale 1ns/1ps
module serial_match_fsm_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] hist = 4'b0;
    bit   exp_q[$];
    string tag_q[$];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    serial_match_fsm dut_i (
        .clk_i (clk),
        .rst_i (rst),
        .bit_i (din),
        .hit_o (hit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: hit_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input bit b, input string tag);
        @(negedge clk);
        din = b;
        hist = {hist[2:0], b};
        exp_q.push_back(hist == 4'b1011);
        tag_q.push_back(tag);
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) send(s[i] == "1", tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: samples 1 ns after the driving edge, well before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() != 0) check(tag_q.pop_front(), hit, exp_q.pop_front());
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1", hit, 1'b0);
        rst = 1'b0;

        send_str("1011011", "R6");
        send_str("0000", "R4");
        send_str("10011", "R7");
        send_str("0000111", "R4");
        send_str("1010", "R5");
        send_str("100", "R5");
        send_str("10111", "R3");
        lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            send(lfsr[0], "R2");
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        drain();

        // R8: bring to GOT_101, then toggle input inside one low phase
        send_str("0101", "R8");
        send(1'b0, "R8");
        send(1'b1, "R8");
        send(1'b0, "R8");
        drain();
        @(negedge clk);
        din = 1'b1;
        hist = 4'b0;
        @(negedge clk);
        din = 1'b0;
        @(negedge clk);
        din = 1'b1;
        @(negedge clk);
        din = 1'b1;
        #0.5;
        check("R8", hit, 1'b1);
        din = 1'b0;
        #0.5;
        check("R8", hit, 1'b0);
        din = 1'b1;
        #0.5;
        check("R8", hit, 1'b1);

        // R1: asynchronous reset between edges clears the flag immediately
        rst = 1'b1;
        #0.3;
        check("R1", hit, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        din = 1'b0;
        hist = 4'b0;
        send_str("1011", "R1");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule